// File: doc/BRIEF.md
# Micro Line Store with MEI Coherence

This block is a tiny fully associative store of one to four lines placed directly inside a datapath. It serves the loads and stores assigned to it. A hit on a load returns data in the same cycle as the request. A miss fetches the line from the backing L1 through a checkout handshake. The L1 always grants a checked-out line exclusively, so a line is only ever Invalid, Exclusive or Modified. No shared copy exists, and the block never snoops.

The L1 drives all coherence. It can shoot down any address at any time. The block acknowledges in the same cycle, returns the line data when that line was Modified, and drops the line. A shootdown always has priority: while one is pending, the datapath port stalls and any outstanding miss waits. Each line holds one word, and the full word address acts as the tag. The datapath holds a request stable until the block marks it served.

Top module: `micro_cache`

## Requirements
- R1: After reset all lines are Invalid. `reqReady`, `coReq`, `evValid`, `sdDirty`, `rspData`, `coAddr`, `evAddr`, `evData` and `sdData` are all zero. Every data and address output reads zero whenever its strobe is low.
- R2: A load that hits raises `reqReady` and drives the line word on `rspData` in the same cycle. The line state does not change.
- R3: A miss raises `coReq` with `coAddr` equal to the missed address. `coReq` stays high until a cycle with `coGrant` high and `sdReq` low. The line is then filled with `coData` in state Exclusive, and the held request hits in the next cycle.
- R4: A store that hits writes `reqWdata` into the line and moves the line to Modified. A later load returns the stored word, and a later shootdown of that address reports it dirty.
- R5: The victim is the lowest-indexed Invalid line. When no line is Invalid, the victim comes from a round-robin pointer that starts at index 0 and advances by one, wrapping, each time the pointer is used.
- R6: A Modified victim is written back before the checkout. `evValid` is high for one cycle with the victim's address on `evAddr` and its data on `evData`, and `coReq` rises in the next cycle.
- R7: `sdAck` follows `sdReq` in the same cycle, and the addressed line becomes Invalid. `sdDirty` is high and `sdData` carries the line word only if the line was Modified. An address that is not present is acknowledged with `sdDirty` low and `sdData` zero.
- R8: While `sdReq` is high, `reqReady` is low, a `coGrant` is not consumed, and a pending write-back is deferred. A write-back whose victim is shot down in that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| reqValid | input | 1 | datapath request present, held until served |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqAddr | input | ADDR_W | word address |
| reqWdata | input | DATA_W | store data |
| reqReady | output | 1 | request served this cycle |
| rspData | output | DATA_W | load data, zero unless a load is served |
| coReq | output | 1 | checkout request to L1 |
| coAddr | output | ADDR_W | address being checked out |
| coGrant | input | 1 | L1 grants the line (level, held until consumed) |
| coData | input | DATA_W | granted line data |
| evValid | output | 1 | write-back of a Modified victim |
| evAddr | output | ADDR_W | write-back address |
| evData | output | DATA_W | write-back data |
| sdReq | input | 1 | shootdown request from L1 |
| sdAddr | input | ADDR_W | shootdown address |
| sdAck | output | 1 | shootdown acknowledge |
| sdDirty | output | 1 | acknowledged line was Modified |
| sdData | output | DATA_W | dirty line data |

## Verification
The bench drives the array until it is full, so that victim choice moves from the lowest-Invalid rule to the round-robin pointer. A pointer that advanced on Invalid fills, or never advanced, would evict the wrong address and return stale data on later hits. A Modified line is written back, shot down and then checked out again, to confirm that stored words survive the round trip through the L1. Losing the Modified state would leave the L1 with the old value. Shootdowns are timed to land on the cycle a grant arrives and on the write-back cycle of the victim itself. A design without priority would fill under a shootdown or write back a line it had already surrendered. Shootdowns of absent and clean addresses confirm that no dirty data is reported for them.

// File: rtl/micro_cache_pkg.sv
package micro_cache_pkg;
  typedef enum logic [1:0] {
    LINE_INV = 2'd0,
    LINE_EXC = 2'd1,
    LINE_MOD = 2'd2
  } lineState_e;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_EVICT = 2'd1,
    MODE_FETCH = 2'd2
  } ctrlMode_e;

  typedef struct packed {
    logic fillEn;
    logic storeEn;
    logic shootEn;
  } strobe_t;
endpackage

// File: rtl/micro_cache_dp.sv
module micro_cache_dp
  import micro_cache_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [IDX_W-1:0]  fillIdx,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic [DATA_W-1:0] fillData,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [ADDR_W-1:0] sdAddr,
  input  logic [IDX_W-1:0]  vicIdx,
  output logic              reqHit,
  output logic [DATA_W-1:0] reqData,
  output logic              sdHit,
  output logic              sdIsMod,
  output logic [DATA_W-1:0] sdLineData,
  output logic [LINES-1:0]  invVec,
  output logic              vicIsMod,
  output logic [ADDR_W-1:0] vicTag,
  output logic [DATA_W-1:0] vicData
);
  lineState_e        lineSt   [LINES];
  logic [ADDR_W-1:0] lineTag  [LINES];
  logic [DATA_W-1:0] lineData [LINES];
  logic [LINES-1:0]  reqHitVec, sdHitVec;
  logic [IDX_W-1:0]  reqIdx, sdIdx;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign reqHitVec[g] = (lineSt[g] != LINE_INV) && (lineTag[g] == reqAddr);
    assign sdHitVec[g]  = (lineSt[g] != LINE_INV) && (lineTag[g] == sdAddr);
    assign invVec[g]    = (lineSt[g] == LINE_INV);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        lineSt[g]   <= LINE_INV;
        lineTag[g]  <= '0;
        lineData[g] <= '0;
      end else if (strb.shootEn && sdHitVec[g]) begin
        lineSt[g] <= LINE_INV;
      end else if (strb.fillEn && fillIdx == IDX_W'(g)) begin
        lineSt[g]   <= LINE_EXC;
        lineTag[g]  <= fillAddr;
        lineData[g] <= fillData;
      end else if (strb.storeEn && reqHitVec[g]) begin
        lineSt[g]   <= LINE_MOD;
        lineData[g] <= reqWdata;
      end
    end

    // R7
    shoot_inval_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.shootEn && sdHitVec[g]) |=> (lineSt[g] == LINE_INV));
    // R4
    store_mod_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.storeEn && reqHitVec[g] && !strb.shootEn) |=> (lineSt[g] == LINE_MOD));
  end

  always_comb begin
    reqIdx = '0;
    sdIdx  = '0;
    for (int i = 0; i < LINES; i++) begin
      if (reqHitVec[i]) reqIdx = IDX_W'(i);
      if (sdHitVec[i])  sdIdx  = IDX_W'(i);
    end
  end

  assign reqHit     = |reqHitVec;
  assign reqData    = lineData[reqIdx];
  assign sdHit      = |sdHitVec;
  assign sdIsMod    = (lineSt[sdIdx] == LINE_MOD);
  assign sdLineData = lineData[sdIdx];
  assign vicIsMod   = (lineSt[vicIdx] == LINE_MOD);
  assign vicTag     = lineTag[vicIdx];
  assign vicData    = lineData[vicIdx];

  // R3
  unique_req_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqHitVec));
  // R7
  unique_sd_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sdHitVec));
endmodule

// File: rtl/micro_cache_ctrl.sv
module micro_cache_ctrl
  import micro_cache_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqHit,
  input  logic              sdReq,
  input  logic              coGrant,
  input  logic [LINES-1:0]  invVec,
  input  logic              vicIsMod,
  output strobe_t           strb,
  output logic [IDX_W-1:0]  vicIdx,
  output logic [ADDR_W-1:0] missAddr,
  output logic              reqReady,
  output logic              coReq,
  output logic [ADDR_W-1:0] coAddr,
  output logic              evFire
);
  ctrlMode_e        mode;
  logic [IDX_W-1:0] victReg, rrPtr, candIdx;
  logic             anyInv, missNow;

  always_comb begin
    anyInv  = |invVec;
    candIdx = rrPtr;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (invVec[i]) candIdx = IDX_W'(i);
    end
  end

  assign vicIdx  = (mode == MODE_IDLE) ? candIdx : victReg;
  assign missNow = (mode == MODE_IDLE) && !sdReq && reqValid && !reqHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode     <= MODE_IDLE;
      victReg  <= '0;
      rrPtr    <= '0;
      missAddr <= '0;
    end else begin
      case (mode)
        MODE_IDLE: if (missNow) begin
          victReg  <= candIdx;
          missAddr <= reqAddr;
          if (!anyInv) rrPtr <= (rrPtr == IDX_W'(LINES - 1)) ? '0 : rrPtr + 1'b1;
          mode <= vicIsMod ? MODE_EVICT : MODE_FETCH;
        end
        MODE_EVICT: if (!sdReq) mode <= MODE_FETCH;
        MODE_FETCH: if (!sdReq && coGrant) mode <= MODE_IDLE;
        default: mode <= MODE_IDLE;
      endcase
    end
  end

  assign strb.shootEn = sdReq;
  assign strb.fillEn  = (mode == MODE_FETCH) && !sdReq && coGrant;
  assign strb.storeEn = (mode == MODE_IDLE) && !sdReq && reqValid && reqWrite && reqHit;
  assign reqReady     = (mode == MODE_IDLE) && !sdReq && reqValid && reqHit;
  assign coReq        = (mode == MODE_FETCH);
  assign coAddr       = coReq ? missAddr : '0;
  assign evFire       = (mode == MODE_EVICT) && !sdReq && vicIsMod;

  // R3
  co_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (coReq && !(coGrant && !sdReq)) |=> (coReq && $stable(coAddr)));
  // R6
  ev_then_co_chk: assert property (@(posedge clk) disable iff (!rstN)
    evFire |=> coReq);
  // R8
  sd_blocks_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (coReq && sdReq) |=> coReq);
endmodule

// File: rtl/micro_cache.sv
module micro_cache
  import micro_cache_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic [DATA_W-1:0] rspData,
  output logic              coReq,
  output logic [ADDR_W-1:0] coAddr,
  input  logic              coGrant,
  input  logic [DATA_W-1:0] coData,
  output logic              evValid,
  output logic [ADDR_W-1:0] evAddr,
  output logic [DATA_W-1:0] evData,
  input  logic              sdReq,
  input  logic [ADDR_W-1:0] sdAddr,
  output logic              sdAck,
  output logic              sdDirty,
  output logic [DATA_W-1:0] sdData
);
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;

  strobe_t           strb;
  logic [IDX_W-1:0]  vicIdx;
  logic [ADDR_W-1:0] missAddr, vicTag;
  logic [DATA_W-1:0] reqData, sdLineData, vicData;
  logic              reqHit, sdHit, sdIsMod, vicIsMod;
  logic [LINES-1:0]  invVec;

  micro_cache_ctrl #(.LINES(LINES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqHit(reqHit), .sdReq(sdReq), .coGrant(coGrant),
    .invVec(invVec), .vicIsMod(vicIsMod), .strb(strb), .vicIdx(vicIdx),
    .missAddr(missAddr), .reqReady(reqReady), .coReq(coReq), .coAddr(coAddr),
    .evFire(evValid)
  );

  micro_cache_dp #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .fillIdx(vicIdx), .fillAddr(missAddr),
    .fillData(coData), .reqAddr(reqAddr), .reqWdata(reqWdata), .sdAddr(sdAddr),
    .vicIdx(vicIdx), .reqHit(reqHit), .reqData(reqData), .sdHit(sdHit),
    .sdIsMod(sdIsMod), .sdLineData(sdLineData), .invVec(invVec),
    .vicIsMod(vicIsMod), .vicTag(vicTag), .vicData(vicData)
  );

  assign rspData = (reqReady && !reqWrite) ? reqData : '0;
  assign sdAck   = sdReq;
  assign sdDirty = sdReq && sdHit && sdIsMod;
  assign sdData  = sdDirty ? sdLineData : '0;
  assign evAddr  = evValid ? vicTag : '0;
  assign evData  = evValid ? vicData : '0;
endmodule

// File: tb/test_micro_cache.sv
`timescale 1ns/1ps
module test_micro_cache;
  localparam int L = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqAddr = '0, sdAddr = '0, coAddr, evAddr;
  logic [31:0] reqWdata = '0, coData = '0, rspData, evData, sdData;
  logic reqReady, coReq, coGrant = 1'b0, evValid, sdReq = 1'b0, sdAck, sdDirty;

  int compared = 0, mismatched = 0;
  int mState[L];
  logic [15:0] mTag[L];
  logic [31:0] mData[L];
  int mRr, mMode, mVict;
  logic [15:0] mMiss;
  logic [31:0] l1mem[int];

  always #2.5 clk = ~clk;

  micro_cache i_micro_cache (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady), .rspData(rspData),
    .coReq(coReq), .coAddr(coAddr), .coGrant(coGrant), .coData(coData),
    .evValid(evValid), .evAddr(evAddr), .evData(evData), .sdReq(sdReq),
    .sdAddr(sdAddr), .sdAck(sdAck), .sdDirty(sdDirty), .sdData(sdData)
  );

  function automatic logic [31:0] memRead(logic [15:0] a);
    if (l1mem.exists(int'(a))) return l1mem[int'(a)];
    return {16'hC0DE, a};
  endfunction

  function automatic int findLine(logic [15:0] a);
    for (int i = 0; i < L; i++)
      if (mState[i] != 0 && mTag[i] == a) return i;
    return -1;
  endfunction

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < L; i++) begin mState[i] = 0; mTag[i] = '0; mData[i] = '0; end
      mRr = 0; mMode = 0; mVict = 0; mMiss = '0;
    end else begin
      int s, h, v;
      s = findLine(sdAddr);
      h = findLine(reqAddr);
      if (sdReq && s >= 0) begin
        if (mState[s] == 2) l1mem[int'(mTag[s])] = mData[s];
        mState[s] = 0;
      end
      if (!sdReq) begin
        if (mMode == 0 && reqValid) begin
          if (h >= 0) begin
            if (reqWrite) begin mData[h] = reqWdata; mState[h] = 2; end
          end else begin
            v = -1;
            for (int i = 0; i < L; i++) if (mState[i] == 0 && v < 0) v = i;
            if (v < 0) begin v = mRr; mRr = (mRr + 1) % L; end
            mVict = v; mMiss = reqAddr;
            mMode = (mState[v] == 2) ? 1 : 2;
          end
        end else if (mMode == 1) begin
          if (mState[mVict] == 2) l1mem[int'(mTag[mVict])] = mData[mVict];
          mMode = 2;
        end else if (mMode == 2 && coGrant) begin
          mTag[mVict] = mMiss; mData[mVict] = memRead(mMiss); mState[mVict] = 1;
          mMode = 0;
        end
      end
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    int h, s;
    logic eReady, eDirty, eEv, eCo;
    h = findLine(reqAddr);
    s = findLine(sdAddr);
    eReady = rstN && mMode == 0 && !sdReq && reqValid && h >= 0;
    eDirty = rstN && sdReq && s >= 0 && mState[s] == 2;
    eEv    = rstN && mMode == 1 && !sdReq && mState[mVict] == 2;
    eCo    = rstN && mMode == 2;
    chk("R2/R8", "reqReady", 32'(reqReady), 32'(eReady));
    chk("R2", "rspData", rspData, (eReady && !reqWrite) ? mData[h] : 32'h0);
    chk("R3", "coReq", 32'(coReq), 32'(eCo));
    chk("R3", "coAddr", 32'(coAddr), eCo ? 32'(mMiss) : 32'h0);
    chk("R6", "evValid", 32'(evValid), 32'(eEv));
    chk("R6", "evAddr", 32'(evAddr), eEv ? 32'(mTag[mVict]) : 32'h0);
    chk("R6", "evData", evData, eEv ? mData[mVict] : 32'h0);
    chk("R7", "sdAck", 32'(sdAck), 32'(sdReq));
    chk("R7", "sdDirty", 32'(sdDirty), 32'(eDirty));
    chk("R7", "sdData", sdData, eDirty ? mData[s] : 32'h0);
  endtask

  // one datapath request, held until served (R2 R3 R4 R5 R6)
  task automatic op(logic wr, logic [15:0] a, logic [31:0] d);
    logic served;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    do begin
      #1 compareAll();
      served = reqReady;
      @(negedge clk);
    end while (!served);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic shoot(logic [15:0] a);
    sdReq = 1'b1; sdAddr = a;
    #1 compareAll();
    @(negedge clk);
    sdReq = 1'b0;
    #1 compareAll();
    @(negedge clk);
  endtask

  task automatic shootLater(int d, logic [15:0] a);
    repeat (d) @(negedge clk);
    sdReq = 1'b1; sdAddr = a;
    @(negedge clk);
    sdReq = 1'b0;
  endtask

  // L1 responder: grants two cycles after a checkout appears, holds until consumed
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (coReq) begin
        cnt++;
        if (cnt >= 2) begin coGrant = 1'b1; coData = memRead(coAddr); end
      end else begin
        cnt = 0; coGrant = 1'b0; coData = '0;
      end
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) begin @(negedge clk); #1 compareAll(); end
    @(negedge clk); rstN = 1'b1;
    #1 compareAll();
    @(negedge clk);
    // R3 miss then R2 hit
    op(0, 16'h0010, 0);
    op(0, 16'h0010, 0);
    // R4 store hit then load
    op(1, 16'h0010, 32'h1111_AAAA);
    op(0, 16'h0010, 0);
    // R5 invalid-first fills
    op(0, 16'h0020, 0);
    op(0, 16'h0030, 0);
    op(0, 16'h0040, 0);
    // R5 round robin index 0 (Modified) -> R6 write-back
    op(0, 16'h0050, 0);
    op(1, 16'h0030, 32'h3333_BBBB);
    op(0, 16'h0060, 0);
    // R7 dirty, absent, clean shootdowns
    shoot(16'h0030);
    shoot(16'h0099);
    shoot(16'h0040);
    // R5 lowest invalid, R4 written-back word returns through the L1
    op(0, 16'h0070, 0);
    op(0, 16'h0030, 0);
    op(1, 16'h0050, 32'h5555_CCCC);
    op(0, 16'h0080, 0);
    // R8 shootdown coincides with the grant
    fork
      op(0, 16'h0090, 0);
      shootLater(2, 16'h0050);
    join
    op(0, 16'h0050, 0);
    op(1, 16'h0050, 32'h5A5A_0101);
    op(1, 16'h0060, 32'h6666_0202);
    op(1, 16'h0080, 32'h8888_0303);
    op(1, 16'h0090, 32'h9999_0404);
    // R8 shootdown of the victim in its write-back cycle
    fork
      op(0, 16'h00B0, 0);
      shootLater(1, 16'h0050);
    join
    op(0, 16'h0050, 0);
    op(0, 16'h0080, 0);
    repeat (3) begin #1 compareAll(); @(negedge clk); end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule